// File: doc/BRIEF.md
# Fixed-Latency Link Transmit Framer

This block packs a 24-bit luminosity payload into a 32-bit word once per 40 MHz bunch tick. It moves the word across a 16-entry dual-clock FIFO into a 50 MHz word domain. From there it drives each word onto a 16-bit bus at 100 MHz as two beats, toward an external serializer. The payload carries 16 photomultiplier hit bits, 4 fiber hit bits, an orbit flag for bunch-counter zero, a live/valid bit and 2 spare bits. Their arrangement inside the 24 bits belongs to the producer. The block carries the 24 bits untouched.

The word domain runs faster than the fill rate, so some 50 MHz cycles find nothing to send. In those slots the block sends a fixed alignment word, which lets the receiver find word boundaries. The link therefore carries a word in every slot. Data words carry a tag in their upper byte so they cannot be mistaken for the alignment pattern. After reset the block sends only alignment words until the FIFO has built a small reserve. From then on, every accepted payload leaves in order and none is dropped.

The three clocks are derived from one reference. The 100 MHz clock must rise together with every rising edge of the 50 MHz clock.

Top module: `lnk_tx_framer`

## Requirements
- R1: While `rst` is high, `txBeat` is 0xBC50, `txFirst` is 0 and `ovfErr` is 0.
- R2: A data word is {0xA5, payload[23:0]}. Its upper 16 bits go out first, with `txFirst` high, and its lower 16 bits follow on the next 100 MHz beat with `txFirst` low. `txFirst` is high on every other beat.
- R3: A 50 MHz slot with no word to send carries the alignment word 0xBC50_BC50 as two beats of 0xBC50, framed like a data word.
- R4: After reset, only alignment words are sent until the read side has seen at least 2 entries in the FIFO. A single stored payload is held back until that point.
- R5: Every payload accepted with `payloadValid` high appears exactly once on the output, in order. This holds when `payloadValid` is high on every 40 MHz cycle.
- R6: A write while the FIFO holds 16 entries is discarded and sets `ovfErr`. The 16 stored words still come out intact and in order.
- R7: Once set, `ovfErr` stays high until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk40 | input | 1 | Bunch-tick clock, write side |
| clk50 | input | 1 | Word clock, FIFO read side |
| clk100 | input | 1 | Beat clock; rises with every clk50 rising edge |
| rst | input | 1 | Asynchronous active-high reset for all domains |
| payloadValid | input | 1 | Write strobe for the current bunch tick (clk40) |
| payload | input | 24 | Luminosity payload for the tick |
| txBeat | output | 16 | Beat toward the serializer (clk100) |
| txFirst | output | 1 | Marks the upper-half beat of each word |
| ovfErr | output | 1 | Sticky FIFO overflow error (clk40 domain) |

## Verification
The read side is faster than the write side, so the FIFO can never fill in normal running. That makes overflow the hardest condition to reach. The bench reaches it by stopping the 50 and 100 MHz clocks together, keeping their phase relation, while the FIFO is empty. It then pushes 18 payloads on the still-running 40 MHz clock. After the clocks restart, it checks that exactly the first 16 payloads come out and that the error flag stays set. A single payload pushed straight after reset checks the startup hold-back. A long run with a write on every tick checks the lossless path at full rate.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  localparam int PAYLOAD_W = 24;
  localparam int WORD_W = 32;
  localparam int BEAT_W = 16;
  localparam int TAG_W = WORD_W - PAYLOAD_W;
  localparam logic [TAG_W-1:0] DATA_TAG = 8'hA5;
  localparam logic [WORD_W-1:0] ALIGN_WORD = 32'hBC50_BC50;

  // read-side strobes from control to datapath, exactly one set per cycle
  typedef struct packed {
    logic pop;
    logic fillIdle;
  } rdStrobe_t;
endpackage

// File: rtl/lnk_fifo.sv
module lnk_fifo
  import lnk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PTR_W = AW + 1
) (
  input  logic              clkWr,
  input  logic              clkRd,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  rdStrobe_t         strobe,
  output logic [PTR_W-1:0]  fillLevel,
  output logic [WORD_W-1:0] rdWord,
  output logic              ovfErr
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wBin, wGray, rBin, rGray;
  logic [PTR_W-1:0] rSync1, rSync2, wSync1, wSync2, wSyncBin;
  logic [PTR_W-1:0] wBinNext, rBinNext;
  logic full;

  // write domain
  assign wBinNext = wBin + PTR_W'(1);
  assign full = (wGray == {~rSync2[PTR_W-1:PTR_W-2], rSync2[PTR_W-3:0]});

  always_ff @(posedge clkWr or posedge rst) begin
    if (rst) begin
      wBin <= '0;
      wGray <= '0;
      ovfErr <= 1'b0;
      rSync1 <= '0;
      rSync2 <= '0;
    end else begin
      rSync1 <= rGray;
      rSync2 <= rSync1;
      if (wrEn) begin
        if (full) begin
          ovfErr <= 1'b1;
        end else begin
          wBin <= wBinNext;
          wGray <= wBinNext ^ (wBinNext >> 1);
        end
      end
    end
  end

  always_ff @(posedge clkWr) begin
    if (wrEn && !full) mem[wBin[AW-1:0]] <= wrData;
  end

  // read domain
  always_comb begin
    for (int i = 0; i < PTR_W; i++) wSyncBin[i] = ^(wSync2 >> i);
  end
  assign fillLevel = wSyncBin - rBin;
  assign rBinNext = rBin + PTR_W'(1);

  always_ff @(posedge clkRd or posedge rst) begin
    if (rst) begin
      rBin <= '0;
      rGray <= '0;
      wSync1 <= '0;
      wSync2 <= '0;
      rdWord <= ALIGN_WORD;
    end else begin
      wSync1 <= wGray;
      wSync2 <= wSync1;
      if (strobe.pop) begin
        rdWord <= mem[rBin[AW-1:0]];
        rBin <= rBinNext;
        rGray <= rBinNext ^ (rBinNext >> 1);
      end else if (strobe.fillIdle) begin
        rdWord <= ALIGN_WORD;
      end
    end
  end

  assert_ovf_sticky_R7: assert property (@(posedge clkWr) disable iff (rst)
    ovfErr |=> ovfErr);
  assert_pop_nonempty_R5: assert property (@(posedge clkRd) disable iff (rst)
    strobe.pop |-> (fillLevel != '0));
endmodule

// File: rtl/lnk_ctrl.sv
module lnk_ctrl
  import lnk_pkg::*;
#(
  parameter int PTR_W = 5,
  parameter int START_LEVEL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] fillLevel,
  output rdStrobe_t        strobe
);
  logic started, goNow;

  assign goNow = started | (fillLevel >= PTR_W'(START_LEVEL));

  always_comb begin
    strobe.pop = goNow && (fillLevel != '0);
    strobe.fillIdle = !strobe.pop;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) started <= 1'b0;
    else if (goNow) started <= 1'b1;
  end

  assert_started_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    started |=> started);
endmodule

// File: rtl/lnk_beat.sv
module lnk_beat
  import lnk_pkg::*;
(
  input  logic              clkWord,
  input  logic              clkBeat,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  output logic [BEAT_W-1:0] beat,
  output logic              first
);
  logic wordTog, togSeen;
  logic [BEAT_W-1:0] lowHold;

  always_ff @(posedge clkWord or posedge rst) begin
    if (rst) wordTog <= 1'b0;
    else wordTog <= ~wordTog;
  end

  // a toggle not yet seen marks the beat edge right after a new word
  always_ff @(posedge clkBeat or posedge rst) begin
    if (rst) begin
      togSeen <= 1'b0;
      beat <= ALIGN_WORD[WORD_W-1 -: BEAT_W];
      lowHold <= ALIGN_WORD[BEAT_W-1:0];
      first <= 1'b0;
    end else begin
      togSeen <= wordTog;
      if (wordTog != togSeen) begin
        beat <= word[WORD_W-1 -: BEAT_W];
        lowHold <= word[BEAT_W-1:0];
        first <= 1'b1;
      end else begin
        beat <= lowHold;
        first <= 1'b0;
      end
    end
  end

  assert_first_alternates_R2: assert property (@(posedge clkBeat) disable iff (rst)
    first |=> !first);
  assert_first_tag_R3: assert property (@(posedge clkBeat) disable iff (rst)
    first |-> (beat[BEAT_W-1 -: TAG_W] == DATA_TAG || beat == ALIGN_WORD[WORD_W-1 -: BEAT_W]));
endmodule

// File: rtl/lnk_tx_framer.sv
module lnk_tx_framer
  import lnk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int START_LEVEL = 2,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic                 clk40,
  input  logic                 clk50,
  input  logic                 clk100,
  input  logic                 rst,
  input  logic                 payloadValid,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic [BEAT_W-1:0]    txBeat,
  output logic                 txFirst,
  output logic                 ovfErr
);
  rdStrobe_t strobe;
  logic [PTR_W-1:0] fillLevel;
  logic [WORD_W-1:0] rdWord;

  lnk_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clkWr(clk40), .clkRd(clk50), .rst(rst),
    .wrEn(payloadValid), .wrData({DATA_TAG, payload}),
    .strobe(strobe), .fillLevel(fillLevel), .rdWord(rdWord), .ovfErr(ovfErr)
  );

  lnk_ctrl #(.PTR_W(PTR_W), .START_LEVEL(START_LEVEL)) u_ctrl (
    .clk(clk50), .rst(rst), .fillLevel(fillLevel), .strobe(strobe)
  );

  lnk_beat u_beat (
    .clkWord(clk50), .clkBeat(clk100), .rst(rst),
    .word(rdWord), .beat(txBeat), .first(txFirst)
  );
endmodule

// File: tb/lnk_tx_framer_tb.sv
`timescale 1ns/1ps
module lnk_tx_framer_tb;
  logic clk40 = 1'b0, clk50 = 1'b0, clk100 = 1'b0;
  logic rst = 1'b1;
  logic payloadValid = 1'b0;
  logic [23:0] payload = '0;
  logic [15:0] txBeat;
  logic txFirst, ovfErr;
  bit runRd = 1'b1;
  logic [1:0] ph = 2'd3;

  int checks = 0, fails = 0;
  int dataCnt = 0, alignCnt = 0;
  logic [23:0] expq[$];
  string phaseReq = "R5";
  bit haveHi = 0, synced = 0;
  logic [15:0] hiHold;

  lnk_tx_framer u_dut (
    .clk40(clk40), .clk50(clk50), .clk100(clk100), .rst(rst),
    .payloadValid(payloadValid), .payload(payload),
    .txBeat(txBeat), .txFirst(txFirst), .ovfErr(ovfErr)
  );

  // 50 MHz word clock with a 100 MHz beat clock rising on its edges; both can be frozen
  initial forever begin
    #5;
    if (runRd) begin
      ph = ph + 2'd1;
      clk100 = (ph == 2'd0) || (ph == 2'd2);
      clk50 = (ph == 2'd0) || (ph == 2'd1);
    end
  end
  initial forever #12.5 clk40 = ~clk40;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(logic [23:0] p);
    return {8'hA5, p};
  endfunction

  // rebuild words from beats and compare against the expected queue
  always @(negedge clk100) begin
    if (rst) begin
      haveHi = 0;
      synced = 0;
    end else if (txFirst) begin
      if (haveHi) check(0, "R2", "flag on two beats in a row", {16'h0, txBeat}, 32'h0);
      hiHold = txBeat;
      haveHi = 1;
      synced = 1;
    end else if (synced) begin
      if (!haveHi) check(0, "R2", "two beats without flag", {16'h0, txBeat}, 32'h0);
      else begin
        logic [31:0] w;
        w = {hiHold, txBeat};
        haveHi = 0;
        if (w == 32'hBC50_BC50) alignCnt++;
        else if (expq.size() == 0) check(0, phaseReq, "unexpected data word", w, 32'hBC50_BC50);
        else begin
          check(w == expWord(expq[0]), phaseReq, "data word", w, expWord(expq[0]));
          void'(expq.pop_front());
          dataCnt++;
        end
      end
    end
  end

  task automatic push(logic [23:0] p, bit accepted);
    @(negedge clk40);
    payloadValid = 1'b1;
    payload = p;
    if (accepted) expq.push_back(p);
    @(negedge clk40);
    payloadValid = 1'b0;
  endtask

  task automatic idle40(int n);
    repeat (n) @(negedge clk40);
  endtask

  task automatic waitDrain(string req);
    for (int i = 0; i < 4000 && expq.size() != 0; i++) @(posedge clk50);
    repeat (10) @(posedge clk50);
    check(expq.size() == 0, req, "words left undelivered", expq.size(), 0);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int a0, d0;
    void'($urandom(32'd7391));
    #63;
    check(txBeat == 16'hBC50, "R1", "txBeat in reset", txBeat, 16'hBC50);
    check(txFirst == 1'b0, "R1", "txFirst in reset", txFirst, 0);
    check(ovfErr == 1'b0, "R1", "ovfErr in reset", ovfErr, 0);
    #40 rst = 1'b0;

    // R3: idle link carries alignment only
    idle40(40);
    check(alignCnt > 20 && dataCnt == 0, "R3", "alignment words on idle link", alignCnt, 21);

    // R4: lone entry held back after reset
    phaseReq = "R4";
    push(24'h123456, 1);
    idle40(50);
    check(dataCnt == 0, "R4", "lone entry sent", dataCnt, 0);
    d0 = dataCnt;
    push(24'h654321, 1);
    waitDrain("R4");
    check(dataCnt == d0 + 2, "R4", "both entries released", dataCnt, d0 + 2);

    // R2 corner payloads, R5 random traffic
    phaseReq = "R2";
    push(24'h000000, 1);
    push(24'hFFFFFF, 1);
    push(24'h00BC50, 1);
    push(24'hBC50BC, 1);
    waitDrain("R2");
    phaseReq = "R5";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk40);
      if (($urandom % 10) < 7) begin
        payloadValid = 1'b1;
        payload = 24'($urandom);
        expq.push_back(payload);
      end else payloadValid = 1'b0;
    end
    // R5 full rate: a write on every tick
    for (int i = 0; i < 300; i++) begin
      @(negedge clk40);
      payloadValid = 1'b1;
      payload = 24'($urandom);
      expq.push_back(payload);
    end
    @(negedge clk40) payloadValid = 1'b0;
    waitDrain("R5");
    check(ovfErr == 1'b0, "R5", "no overflow at full rate", ovfErr, 0);

    // R6: freeze the read clocks and overfill
    phaseReq = "R6";
    idle40(20);
    runRd = 0;
    #40;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk40);
      payloadValid = 1'b1;
      payload = 24'h600000 + 24'(i);
      expq.push_back(payload);
    end
    @(negedge clk40) payloadValid = 1'b1; payload = 24'hDEAD01;
    @(negedge clk40) payloadValid = 1'b1; payload = 24'hDEAD02;
    @(negedge clk40) payloadValid = 1'b0;
    check(ovfErr == 1'b1, "R6", "overflow flag", ovfErr, 1);
    a0 = dataCnt;
    runRd = 1;
    waitDrain("R6");
    check(dataCnt == a0 + 16, "R6", "stored words delivered", dataCnt, a0 + 16);

    // R7: sticky through later traffic, cleared only by reset
    phaseReq = "R5";
    for (int i = 0; i < 20; i++) push(24'($urandom), 1);
    waitDrain("R5");
    check(ovfErr == 1'b1, "R7", "flag held after traffic", ovfErr, 1);
    @(negedge clk40) rst = 1'b1;
    #50;
    check(ovfErr == 1'b0, "R7", "flag cleared by reset", ovfErr, 0);
    check(txBeat == 16'hBC50 && txFirst == 1'b0, "R1", "outputs in second reset", {txFirst, txBeat}, 32'hBC50);
    @(negedge clk40) rst = 1'b0;

    // R4 again after the second reset
    phaseReq = "R4";
    d0 = dataCnt;
    push(24'hABCDEF, 1);
    idle40(50);
    check(dataCnt == d0, "R4", "lone entry after second reset", dataCnt, d0);
    push(24'h0F0F0F, 1);
    waitDrain("R4");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule